// File: doc/BRIEF.md
# Datapath ALU with Negative and Zero Flags

This block is the combinational arithmetic-logic unit of a small 16-bit processor datapath. It takes two operands and a 4-bit function code. It returns a 16-bit result and two status bits. The functions are add, subtract, bitwise AND, bitwise OR and signed set-less-than. The control unit uses the negative and zero status bits to decide branches.

The same unit serves address arithmetic and the program-counter increment. The datapath multiplexers place the counter on one operand and the constant 1 on the other, then select add. Operand selection, registers and carry chaining between slices live outside the block. The result and flags depend only on the present inputs; there is no state.

Top module: `dp_alu`

## Requirements
- R1: Function code 0 gives A+B, wrapped modulo 2^16; the carry out of bit 15 is discarded.
- R2: Function code 1 gives A-B, wrapped modulo 2^16; a borrow is discarded.
- R3: Function code 2 gives the bitwise AND of A and B.
- R4: Function code 3 gives the bitwise OR of A and B.
- R5: Function code 4 compares A and B as two's-complement signed values. The result is 16'h0001 when A < B and 16'h0000 otherwise, so bits 15..1 are always zero.
- R6: Function codes 5 to 15 give a result of 16'h0000. The flags then show N=0 and Z=1.
- R7: The negative flag equals bit 15 of the result, for every function code.
- R8: The zero flag is 1 exactly when all 16 result bits are 0, for every function code.
- R9: Adding the constant 1 to any value gives that value plus one. 16'hFFFF plus 1 gives 16'h0000 with Z=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 16 | First operand (A) |
| opb_i | input | 16 | Second operand (B), which may be an immediate or a constant |
| func_i | input | 4 | Function code: 0 add, 1 sub, 2 and, 3 or, 4 signed set-less-than, others give zero |
| result_o | output | 16 | Result of the selected function |
| neg_o | output | 1 | Negative flag, equal to result bit 15 |
| zero_o | output | 1 | Zero flag, high when the result is all zeros |

## Verification
Random operand pairs across all sixteen function codes separate the five live functions from one another and from the unused codes. A result that differs from the expected one by a single bit shows a wrong selection or a broken carry.

Directed pairs test the places where an ALU most often fails:
- Operands of opposite sign near the extremes (8000/7FFF) tell signed set-less-than apart from an unsigned compare and from a compare that takes only the sign of the difference.
- Equal operands test the strict inequality.
- Counter values FFFF and 7FFF, incremented by 1, expose a carry chain that drops or keeps the wrap-around bit.
- All-ones results test the negative flag, and cancelling results test the zero flag.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
   localparam int unsigned FUNC_W = 4;

   typedef enum logic [FUNC_W-1:0] {
      FN_ADD = 4'd0,
      FN_SUB = 4'd1,
      FN_AND = 4'd2,
      FN_OR  = 4'd3,
      FN_SLT = 4'd4
   } alu_fn_e;

   // Adder implementations that the generate block can choose from
   localparam int unsigned ADDER_RIPPLE = 0;
   localparam int unsigned ADDER_NATIVE = 1;
endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned STYLE = 0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             ovf_o
);
   import dp_alu_pkg::*;

   logic [WIDTH-1:0] b_eff;

   // Subtraction is A + ~B + 1
   assign b_eff = sub_i ? ~b_i : b_i;

   if (WIDTH < 2) begin : g_bad_width
      $error("dp_alu_addsub: WIDTH must be at least 2");
   end
   if (STYLE != ADDER_RIPPLE && STYLE != ADDER_NATIVE) begin : g_bad_style
      $error("dp_alu_addsub: unknown STYLE");
   end

   if (STYLE == ADDER_RIPPLE) begin : g_ripple
      logic [WIDTH-1:0] carry;
      assign carry[0] = sub_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum_o[i] = a_i[i] ^ b_eff[i] ^ carry[i];
         if (i < WIDTH - 1) begin : g_carry
            assign carry[i+1] = (a_i[i] & b_eff[i]) | (carry[i] & (a_i[i] ^ b_eff[i]));
         end
      end
   end else begin : g_native
      assign sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};
   end

   // Signed overflow: the operands' sign bits agree but the sum's sign bit differs
   assign ovf_o = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);

   always_comb begin
      if (!$isunknown({a_i, b_i, sub_i})) begin
         p_addsub_wrap_r1: assert (sum_o == (sub_i ? WIDTH'(a_i - b_i) : WIDTH'(a_i + b_i)))
            else $error("adder sum wrong (R1/R2)");
      end
   end
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic #(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] or_o
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign and_o[i] = a_i[i] & b_i[i];
      assign or_o[i]  = a_i[i] | b_i[i];
   end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags #(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] res_i,
   output logic             neg_o,
   output logic             zero_o
);
   assign neg_o  = res_i[WIDTH-1];
   assign zero_o = ~(|res_i);

   always_comb begin
      if (!$isunknown(res_i)) begin
         p_zero_only_empty_r8: assert (!zero_o || (res_i == '0))
            else $error("zero flag set on nonzero result (R8)");
         p_neg_sign_r7: assert (neg_o == ($signed(res_i) < 0))
            else $error("negative flag wrong (R7)");
      end
   end
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
   parameter int unsigned WIDTH       = 16,
   parameter int unsigned FN_WIDTH    = 4,
   parameter int unsigned ADDER_STYLE = 0
) (
   input  logic [WIDTH-1:0]    opa_i,
   input  logic [WIDTH-1:0]    opb_i,
   input  logic [FN_WIDTH-1:0] func_i,
   output logic [WIDTH-1:0]    result_o,
   output logic                neg_o,
   output logic                zero_o
);
   import dp_alu_pkg::*;

   if (FN_WIDTH != FUNC_W) begin : g_bad_fn
      $error("dp_alu: FN_WIDTH must match the package function width");
   end

   logic [WIDTH-1:0] sum, and_v, or_v, sel;
   logic             ovf, do_sub, lt;

   // Set-less-than reuses the subtractor
   assign do_sub = (func_i == FN_SUB) || (func_i == FN_SLT);

   dp_alu_addsub #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_addsub (
      .a_i(opa_i), .b_i(opb_i), .sub_i(do_sub), .sum_o(sum), .ovf_o(ovf)
   );

   dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a_i(opa_i), .b_i(opb_i), .and_o(and_v), .or_o(or_v)
   );

   // A < B when the difference's sign bit and the overflow bit differ
   assign lt = sum[WIDTH-1] ^ ovf;

   always_comb begin
      case (func_i)
         FN_ADD, FN_SUB: sel = sum;
         FN_AND:         sel = and_v;
         FN_OR:          sel = or_v;
         FN_SLT:         sel = {{(WIDTH-1){1'b0}}, lt};
         default:        sel = '0;
      endcase
   end

   assign result_o = sel;

   dp_alu_flags #(.WIDTH(WIDTH)) u_flags (
      .res_i(result_o), .neg_o(neg_o), .zero_o(zero_o)
   );

   always_comb begin
      if (!$isunknown({opa_i, opb_i, func_i})) begin
         if (func_i == FN_SLT) begin
            p_slt_signed_r5: assert (result_o == (($signed(opa_i) < $signed(opb_i)) ? WIDTH'(1) : WIDTH'(0)))
               else $error("signed set-less-than wrong (R5)");
         end
         if (func_i > FN_SLT) begin
            p_unused_zero_r6: assert (result_o == '0 && zero_o && !neg_o)
               else $error("unused code gave nonzero output (R6)");
         end
         if (func_i == FN_AND) begin
            p_and_subset_r3: assert ((result_o & ~opa_i) == '0)
               else $error("AND result has a bit that A lacks (R3)");
         end
         if (func_i == FN_OR) begin
            p_or_superset_r4: assert ((opa_i & ~result_o) == '0)
               else $error("OR result lacks a bit of A (R4)");
         end
      end
   end
endmodule

// File: tb/dp_alu_tb.sv
module dp_alu_tb_top;
   logic        clk = 1'b0;
   logic [15:0] a, b, res;
   logic [3:0]  fn;
   logic        neg, zero;
   int          errors = 0;
   int          checks = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   dp_alu dut_i (
      .opa_i(a), .opb_i(b), .func_i(fn),
      .result_o(res), .neg_o(neg), .zero_o(zero)
   );

   function automatic logic [15:0] model(input logic [15:0] x, input logic [15:0] y,
                                         input logic [3:0] f);
      int sx, sy;
      sx = (x[15]) ? int'(x) - 65536 : int'(x);
      sy = (y[15]) ? int'(y) - 65536 : int'(y);
      case (f)
         4'd0:    return 16'((int'(x) + int'(y)) % 65536);
         4'd1:    return 16'((int'(x) - int'(y) + 65536) % 65536);
         4'd2:    return x & y;
         4'd3:    return x | y;
         4'd4:    return (sx < sy) ? 16'd1 : 16'd0;
         default: return 16'd0;
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] f);
      case (f)
         4'd0:    return "R1";
         4'd1:    return "R2";
         4'd2:    return "R3";
         4'd3:    return "R4";
         4'd4:    return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s a=%h b=%h fn=%0d actual=%h expected=%h", req, a, b, fn, act, exp);
      end
   endtask

   // Drive after a rising edge, sample at the falling edge
   task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic [3:0] f,
                        input string req);
      logic [15:0] e;
      @(posedge clk);
      #1;
      a = x; b = y; fn = f;
      @(negedge clk);
      e = model(x, y, f);
      check(req, 32'(res), 32'(e));
      check("R7", 32'(neg), 32'(e[15]));
      check("R8", 32'(zero), 32'(e == 16'd0));
   endtask

   initial begin
      a = '0; b = '0; fn = '0;
      void'($urandom(32'd20240611));
      @(negedge clk);
      // Initial state: zero inputs give a zero result
      check("R8", 32'({neg, zero, res}), 32'({1'b0, 1'b1, 16'd0}));

      apply(16'hFFFF, 16'h0001, 4'd0, "R1");
      apply(16'h8000, 16'h8000, 4'd0, "R1");
      apply(16'h0000, 16'h0001, 4'd1, "R2");
      apply(16'h1234, 16'h1234, 4'd1, "R2");
      apply(16'hF0F0, 16'hFF00, 4'd2, "R3");
      apply(16'h0F0F, 16'h00F0, 4'd3, "R4");
      apply(16'h8000, 16'h7FFF, 4'd4, "R5");
      apply(16'h7FFF, 16'h8000, 4'd4, "R5");
      apply(16'hFFFF, 16'h0001, 4'd4, "R5");
      apply(16'h0001, 16'hFFFF, 4'd4, "R5");
      apply(16'h0005, 16'h0005, 4'd4, "R5");
      apply(16'h8000, 16'h0001, 4'd4, "R5");
      for (int f = 5; f < 16; f++) apply(16'hFFFF, 16'hFFFF, 4'(f), "R6");
      // Program counter increment by the constant 1
      apply(16'hFFFF, 16'h0001, 4'd0, "R9");
      apply(16'h7FFF, 16'h0001, 4'd0, "R9");
      apply(16'h00FE, 16'h0001, 4'd0, "R9");

      for (int i = 0; i < 600; i++) begin
         logic [3:0] f;
         f = (i % 4 == 0) ? 4'($urandom_range(15, 0)) : 4'($urandom_range(4, 0));
         apply(16'($urandom), 16'($urandom), f, req_of(f));
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule